// File: doc/BRIEF.md
# SRAM Chip-Select Access Sequencer

This block turns single read or write requests from an internal port into the strobe sequence for one SRAM-style chip-select area on a simple asynchronous local bus. It drives the bus address, chip select, read strobe, write strobe, a start-of-cycle marker and outgoing data. On reads it captures the incoming data. Every timing interval comes from a set of plain configuration pins. These cover address setup and hold, the delay from chip select to strobe, the delay from strobe release to chip-select release, a coded wait count, a read-hold extension, a marker-width option, and five idle-time fields.

A request is offered with `req_valid` and is taken in a cycle where `req_ready` is high. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low. Once a request is taken, `req_ready` stays low until the access has fully completed, which applies back-pressure for the whole access. An idle interval can be inserted between consecutive accesses. It is placed at the front of the newly accepted access, because its length depends on both the previous access and the new one. Completion is signalled by a one-cycle `done` pulse, with read data on `rdata`.

Top module: `cs_sram_seq`

## Requirements
- R1: During and after reset, `bus_cs_n`, `bus_rd_n`, `bus_we_n` and `bus_bs_n` are high, `req_ready` is high and `done` is low.
- R2: An accepted access occupies G+S+L+T+X+H cycles, made up of idle G, setup S, lead L, strobe T, trail X and hold H. `req_ready` is low for all of these cycles. `done` pulses for exactly one cycle in the cycle that follows them, and `req_ready` is high again in that same cycle.
- R3: The new address appears on `bus_addr` in the first cycle after the idle interval. `bus_cs_n` goes low `cfg_addr_setup` (0–7) cycles later. After `bus_cs_n` rises, the address is held for `cfg_addr_hold` (0–7) cycles before completion, and it stays stable while `bus_cs_n` is low.
- R4: On a read, `bus_rd_n` goes low `cfg_cs_rd` (0–7) cycles after `bus_cs_n` falls. `bus_cs_n` rises `cfg_rd_cs` cycles after `bus_rd_n` rises, plus one more cycle when `cfg_rd_ext` is 1.
- R5: On a write, `bus_we_n` goes low `cfg_cs_we` (0–7) cycles after `bus_cs_n` falls, and `bus_cs_n` rises `cfg_we_cs` (0–7) cycles after `bus_we_n` rises. The write data is on `bus_dout` with `bus_doe` high whenever `bus_we_n` is low.
- R6: The strobe lasts 1+W cycles, where `cfg_wait` codes 0 to 15 give W = 0,1,2,3,4,5,6,7,8,9,11,13,15,17,21,25.
- R7: `bus_bs_n` is low for the first strobe cycle only when `cfg_bs_long`=0, and for the first two when it is 1. With `cfg_bs_long`=1 the strobe lasts at least 2 cycles.
- R8: The idle cycles G ahead of an access depend on the previous access and the current one. Write then write uses `cfg_gap_ww`. Read then write uses `cfg_gap_rw_same` or `cfg_gap_rw_diff`. Read then read uses `cfg_gap_rr_same` or `cfg_gap_rr_diff`. The "same" fields apply when `req_area` equals the area of the previous access. Write then read, and the first access after reset, get G=0.
- R9: On a read, `rdata` holds the value of `bus_din` sampled in the last strobe cycle, and is valid while `done` is high.
- R10: Configuration pins are sampled only in the accepting cycle. Changing them during an access does not alter that access.
- R11: `bus_rd_n` and `bus_we_n` are never low together. A strobe or `bus_bs_n` is low only while `bus_cs_n` is low and the matching strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_area | input | AREA_W | Area identifier used for idle selection |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| cfg_addr_setup | input | 3 | Address to chip-select setup cycles |
| cfg_addr_hold | input | 3 | Chip-select release to end hold cycles |
| cfg_cs_rd | input | 3 | Chip select to read strobe cycles |
| cfg_rd_cs | input | 3 | Read strobe release to chip-select release cycles |
| cfg_cs_we | input | 3 | Chip select to write strobe cycles |
| cfg_we_cs | input | 3 | Write strobe release to chip-select release cycles |
| cfg_wait | input | 4 | Coded wait count |
| cfg_rd_ext | input | 1 | One extra read trail cycle |
| cfg_bs_long | input | 1 | Two-cycle start marker |
| cfg_gap_ww | input | 3 | Idle, write then write |
| cfg_gap_rw_same | input | 3 | Idle, read then write, same area |
| cfg_gap_rw_diff | input | 3 | Idle, read then write, other area |
| cfg_gap_rr_same | input | 3 | Idle, read then read, same area |
| cfg_gap_rr_diff | input | 3 | Idle, read then read, other area |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_bs_n | output | 1 | Start-of-cycle marker, active low |
| bus_dout | output | DATA_W | Outgoing write data |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Incoming read data |

## Verification
The assertions rely on two assumptions about the inputs. First, `rst_n` is asserted before the first clock. Second, a requester does not withdraw or alter a request while it waits for `req_ready`. The interlocks they check (a strobe only inside chip select, exclusive strobes, a stable address, a single-cycle `done`) are expected to hold for any configuration. The stimulus holds `req_valid` and the request fields steady from the first cycle of an offer until its acceptance edge, and drops `req_valid` just after that edge. The next access's configuration is applied while the current one is still running, which exercises R10. Addresses are distinct from one access to the next, so the first cycle the new address appears is unambiguous. `bus_din` is a fixed function of `bus_addr`, so the expected read data follows from the address alone.

// File: rtl/cs_sram_pkg.sv
package cs_sram_pkg;
  localparam int TW  = 3;   // width of a 0..7 timing field
  localparam int WCW = 4;   // width of the coded wait field
  localparam int LW  = 6;   // phase length counter width (max 26)
  localparam int NPH = 6;   // idle, setup, lead, strobe, trail, hold

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_GAP  = 3'd1,
    PH_SU   = 3'd2,
    PH_LEAD = 3'd3,
    PH_STR  = 3'd4,
    PH_TRL  = 3'd5,
    PH_HOLD = 3'd6
  } phase_e;

  // Coded wait count: linear to 9, then steps of 2 to 17, then steps of 4.
  function automatic logic [LW-1:0] wait_cycles(input logic [WCW-1:0] code);
    logic [LW-1:0] v;
    v = {{(LW-WCW){1'b0}}, code};
    if (code <= WCW'(9))       return v;
    else if (code <= WCW'(13)) return (v << 1) - LW'(9);
    else                       return (v << 2) - LW'(35);
  endfunction
endpackage

// File: rtl/cs_sram_gap_sel.sv
module cs_sram_gap_sel #(
  parameter int AREA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [2:0]        g_ww,
  input  logic [2:0]        g_rw_same,
  input  logic [2:0]        g_rw_diff,
  input  logic [2:0]        g_rr_same,
  input  logic [2:0]        g_rr_diff,
  output logic [2:0]        gap
);
  logic              have_prev;
  logic              prev_wr;
  logic [AREA_W-1:0] prev_area;
  logic              same;

  assign same = (prev_area == req_area);

  always_comb begin
    gap = 3'd0;
    if (have_prev) begin
      unique case ({prev_wr, req_write})
        2'b11:   gap = g_ww;
        2'b01:   gap = same ? g_rw_same : g_rw_diff;
        2'b00:   gap = same ? g_rr_same : g_rr_diff;
        default: gap = 3'd0;  // write then read
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      prev_area <= '0;
    end else if (accept) begin
      have_prev <= 1'b1;
      prev_wr   <= req_write;
      prev_area <= req_area;
    end
  end
endmodule

// File: rtl/cs_sram_phase_ctl.sv
module cs_sram_phase_ctl
  import cs_sram_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NPH-1:0][LW-1:0]  lens_in,
  output phase_e                  phase,
  output phase_e                  phase_nxt,
  output logic                    last
);
  logic [NPH-1:0][LW-1:0] lens_q;
  logic [NPH-1:0][LW-1:0] lens_use;
  logic [LW-1:0]          cnt, cnt_nxt;

  assign lens_use = (phase == PH_IDLE) ? lens_in : lens_q;
  assign last     = (cnt == '0);

  // Walk to the next phase with a non-zero length; empty phases are skipped.
  always_comb begin
    int  from;
    logic search, found;
    phase_nxt = phase;
    cnt_nxt   = cnt;
    search    = 1'b0;
    found     = 1'b0;
    from      = 0;
    if (phase == PH_IDLE) begin
      search = start;
    end else if (cnt != '0) begin
      cnt_nxt = cnt - LW'(1);
    end else begin
      search = 1'b1;
      from   = int'(phase);
    end
    if (search) begin
      phase_nxt = PH_IDLE;
      for (int i = 0; i < NPH; i++) begin
        if (!found && i >= from && lens_use[i] != '0) begin
          found     = 1'b1;
          phase_nxt = phase_e'(3'(i + 1));
          cnt_nxt   = lens_use[i] - LW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      lens_q <= '0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
      if (start) lens_q <= lens_in;
    end
  end
endmodule

// File: rtl/cs_sram_seq.sv
module cs_sram_seq
  import cs_sram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int AREA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [AREA_W-1:0] req_area,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic [2:0]        cfg_addr_setup,
  input  logic [2:0]        cfg_addr_hold,
  input  logic [2:0]        cfg_cs_rd,
  input  logic [2:0]        cfg_rd_cs,
  input  logic [2:0]        cfg_cs_we,
  input  logic [2:0]        cfg_we_cs,
  input  logic [3:0]        cfg_wait,
  input  logic              cfg_rd_ext,
  input  logic              cfg_bs_long,
  input  logic [2:0]        cfg_gap_ww,
  input  logic [2:0]        cfg_gap_rw_same,
  input  logic [2:0]        cfg_gap_rw_diff,
  input  logic [2:0]        cfg_gap_rr_same,
  input  logic [2:0]        cfg_gap_rr_diff,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n,
  output logic              bus_bs_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  phase_e                 phase, phase_nxt;
  logic                   last, accept;
  logic [2:0]             gap;
  logic [NPH-1:0][LW-1:0] lens_in;
  logic [LW-1:0]          str_len;

  logic              wr_q, bsl_q, bs_more;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_eff, bsl_eff, in_cs_nxt, drive_nxt;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] wd_eff;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  cs_sram_gap_sel #(.AREA_W(AREA_W)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_area  (req_area),
    .g_ww      (cfg_gap_ww),
    .g_rw_same (cfg_gap_rw_same),
    .g_rw_diff (cfg_gap_rw_diff),
    .g_rr_same (cfg_gap_rr_same),
    .g_rr_diff (cfg_gap_rr_diff),
    .gap       (gap)
  );

  always_comb begin
    str_len = wait_cycles(cfg_wait) + LW'(1);
    if (cfg_bs_long && str_len < LW'(2)) str_len = LW'(2);
    lens_in[0] = LW'(gap);
    lens_in[1] = LW'(cfg_addr_setup);
    lens_in[2] = req_write ? LW'(cfg_cs_we) : LW'(cfg_cs_rd);
    lens_in[3] = str_len;
    lens_in[4] = req_write ? LW'(cfg_we_cs) : LW'(cfg_rd_cs) + LW'(cfg_rd_ext);
    lens_in[5] = LW'(cfg_addr_hold);
  end

  cs_sram_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .lens_in   (lens_in),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .last      (last)
  );

  assign wr_eff    = accept ? req_write   : wr_q;
  assign bsl_eff   = accept ? cfg_bs_long : bsl_q;
  assign addr_eff  = accept ? req_addr    : addr_q;
  assign wd_eff    = accept ? req_wdata   : wd_q;
  assign in_cs_nxt = (phase_nxt == PH_LEAD) || (phase_nxt == PH_STR) || (phase_nxt == PH_TRL);
  assign drive_nxt = (phase_nxt == PH_SU) || (phase_nxt == PH_LEAD) || (phase_nxt == PH_STR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      bsl_q    <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      bus_addr <= '0;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
      bus_cs_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_we_n <= 1'b1;
      bus_bs_n <= 1'b1;
      bs_more  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        wr_q   <= req_write;
        bsl_q  <= cfg_bs_long;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
      bus_cs_n <= !in_cs_nxt;
      bus_rd_n <= !((phase_nxt == PH_STR) && !wr_eff);
      bus_we_n <= !((phase_nxt == PH_STR) && wr_eff);
      bus_doe  <= in_cs_nxt && wr_eff;
      if (drive_nxt) begin
        bus_addr <= addr_eff;
        bus_dout <= wd_eff;
      end
      if ((phase_nxt == PH_STR) && (phase != PH_STR)) begin
        bus_bs_n <= 1'b0;
        bs_more  <= bsl_eff;
      end else if ((phase_nxt == PH_STR) && !bus_bs_n && bs_more) begin
        bus_bs_n <= 1'b0;
        bs_more  <= 1'b0;
      end else begin
        bus_bs_n <= 1'b1;
        bs_more  <= 1'b0;
      end
      done <= (phase != PH_IDLE) && (phase_nxt == PH_IDLE);
      if ((phase == PH_STR) && last && !wr_q) rdata <= bus_din;
    end
  end
endmodule

// File: rtl/cs_sram_seq_chk.sv
module cs_sram_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_we_n,
  input logic              bus_bs_n,
  input logic              bus_doe,
  input logic [ADDR_W-1:0] bus_addr
);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  p_rd_in_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_cs_n);

  p_we_in_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (!bus_cs_n && bus_doe));

  p_excl_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we_n));

  p_bs_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bs_n |-> (!bus_rd_n || !bus_we_n));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !done) |-> (bus_cs_n && bus_rd_n && bus_we_n));
endmodule

bind cs_sram_seq cs_sram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_we_n  (bus_we_n),
  .bus_bs_n  (bus_bs_n),
  .bus_doe   (bus_doe),
  .bus_addr  (bus_addr)
);

// File: tb/cs_sram_seq_tb.sv
`timescale 1ns/1ps
module cs_sram_seq_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RW = 2;

  typedef struct {
    int su, hd, crd, rdc, cwe, wec, wcode, rdx, bsl;
    int gww, grws, grwd, grrs, grrd;
  } cfg_t;

  typedef struct {
    bit          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    int t_addr, t_cs, t_str, t_cs_last, n_str, n_bs, t_done;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [RW-1:0] req_area = '0;
  logic req_ready, done, bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n, bus_doe;
  logic [DW-1:0] rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;
  cfg_t cfg = '{default: 0};

  always #2 clk = ~clk;
  assign bus_din = bus_addr ^ 16'h5A3C;

  cs_sram_seq #(.ADDR_W(AW), .DATA_W(DW), .AREA_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_area(req_area),
    .done(done), .rdata(rdata),
    .cfg_addr_setup(3'(cfg.su)), .cfg_addr_hold(3'(cfg.hd)),
    .cfg_cs_rd(3'(cfg.crd)), .cfg_rd_cs(3'(cfg.rdc)),
    .cfg_cs_we(3'(cfg.cwe)), .cfg_we_cs(3'(cfg.wec)),
    .cfg_wait(4'(cfg.wcode)), .cfg_rd_ext(1'(cfg.rdx)), .cfg_bs_long(1'(cfg.bsl)),
    .cfg_gap_ww(3'(cfg.gww)), .cfg_gap_rw_same(3'(cfg.grws)),
    .cfg_gap_rw_diff(3'(cfg.grwd)), .cfg_gap_rr_same(3'(cfg.grrs)),
    .cfg_gap_rr_diff(3'(cfg.grrd)),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int wmap(input int c);
    case (c)
      10: return 11;
      11: return 13;
      12: return 15;
      13: return 17;
      14: return 21;
      15: return 25;
      default: return c;
    endcase
  endfunction

  bit have_prev = 0;
  bit prev_wr = 0;
  int prev_area = 0;

  // Driver: computes the expected timing from the requirements and queues it.
  task automatic access(input bit wr, input int a, input int area, input int wd, input cfg_t c);
    int gap, lead, str, trl;
    bit same;
    exp_t e;
    same = have_prev && (prev_area == area);
    if (!have_prev || (prev_wr && !wr)) gap = 0;          // R8 first / write-read
    else if (prev_wr && wr)             gap = c.gww;
    else if (wr)                        gap = same ? c.grws : c.grwd;
    else                                gap = same ? c.grrs : c.grrd;
    lead = wr ? c.cwe : c.crd;
    str  = wmap(c.wcode) + 1;
    if (c.bsl != 0 && str < 2) str = 2;
    trl  = wr ? c.wec : c.rdc + c.rdx;
    e.wr        = wr;
    e.addr      = AW'(a);
    e.wd        = DW'(wd);
    e.t_addr    = gap + 1;
    e.t_cs      = gap + c.su + 1;
    e.t_str     = gap + c.su + lead + 1;
    e.t_cs_last = gap + c.su + lead + str + trl;
    e.n_str     = str;
    e.n_bs      = (c.bsl != 0) ? 2 : 1;
    e.t_done    = e.t_cs_last + c.hd + 1;
    q.push_back(e);
    have_prev = 1;
    prev_wr   = wr;
    prev_area = area;
    @(posedge clk); #1;
    cfg       = c;   // R10: lands while the previous access may still run
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = DW'(wd);
    req_area  = RW'(area);
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  bit busy = 0;
  int k, t_addr, t_cs, t_str, t_csl, n_str, n_bs, n_wrong, rdy_bad, wd_bad;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy && done) chk(1'b0, "R2 done without access", 1, 0);
      if (busy) begin
        k++;
        if (t_addr == 0 && bus_addr == cur.addr) t_addr = k;
        if (!bus_cs_n) begin
          if (t_cs == 0) t_cs = k;
          t_csl = k;
        end
        if (cur.wr ? !bus_we_n : !bus_rd_n) begin
          n_str++;
          if (t_str == 0) t_str = k;
          if (cur.wr && (bus_dout != cur.wd || !bus_doe)) wd_bad++;
        end
        if (cur.wr ? !bus_rd_n : !bus_we_n) n_wrong++;
        if (!bus_bs_n) n_bs++;
        if (done) begin
          chk(t_addr == cur.t_addr, "R8 R3 idle gap / address appears", t_addr, cur.t_addr);
          chk(t_cs == cur.t_cs, "R3 address setup to CSn", t_cs, cur.t_cs);
          chk(t_str == cur.t_str, cur.wr ? "R5 CSn to WEn" : "R4 CSn to RDn", t_str, cur.t_str);
          chk(t_csl == cur.t_cs_last, cur.wr ? "R5 WEn to CSn release" : "R4 RDn to CSn release",
              t_csl, cur.t_cs_last);
          chk(k == cur.t_done, "R2 R10 completion cycle / hold", k, cur.t_done);
          chk(n_str == cur.n_str, "R6 strobe length", n_str, cur.n_str);
          chk(n_bs == cur.n_bs, "R7 BSn width", n_bs, cur.n_bs);
          chk(n_wrong == 0, "R11 wrong strobe asserted", n_wrong, 0);
          chk(rdy_bad == 0, "R2 ready high while busy", rdy_bad, 0);
          if (cur.wr) chk(wd_bad == 0, "R5 write data while WEn low", wd_bad, 0);
          else chk(rdata == (cur.addr ^ 16'h5A3C), "R9 read data", int'(rdata),
                   int'(cur.addr ^ 16'h5A3C));
          void'(q.pop_front());
          busy = 0;
        end else if (req_ready) begin
          rdy_bad++;
        end
      end
      if (req_valid && req_ready) begin
        busy = 1;
        cur = q[0];
        k = 0; t_addr = 0; t_cs = 0; t_str = 0; t_csl = 0;
        n_str = 0; n_bs = 0; n_wrong = 0; rdy_bad = 0; wd_bad = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_t c;
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_we_n && bus_bs_n, "R1 strobes high in reset",
        int'({bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n}), 15);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done, "R1 ready after reset", int'({req_ready, done}), 2);
    chk(bus_cs_n && bus_rd_n && bus_we_n && bus_bs_n, "R1 strobes high after reset",
        int'({bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n}), 15);

    c = '{default: 0};
    access(0, 16'h0100, 0, 0, c);                      // minimal read, first access
    c = '{default: 0};
    c.su = 2; c.hd = 3; c.cwe = 1; c.wec = 2; c.wcode = 3; c.grws = 4; c.grwd = 1;
    access(1, 16'h0102, 0, 16'hBEEF, c);               // read->write same area
    c = '{default: 0};
    c.gww = 5; c.wcode = 10; c.cwe = 3;
    access(1, 16'h0104, 1, 16'h1234, c);               // write->write
    c = '{default: 0};
    c.crd = 2; c.rdc = 1; c.rdx = 1; c.wcode = 13; c.grrs = 6; c.grrd = 6;
    access(0, 16'h0106, 1, 0, c);                      // write->read: no gap
    c = '{default: 0};
    c.grrs = 3; c.grrd = 6; c.wcode = 15; c.bsl = 1;
    access(0, 16'h0108, 1, 0, c);                      // read->read same area
    c = '{default: 0};
    c.grrs = 3; c.grrd = 6; c.wcode = 0; c.bsl = 1;
    access(0, 16'h010A, 2, 0, c);                      // read->read other area, BS stretch
    c = '{default: 0};
    c.grws = 7; c.grwd = 2; c.wcode = 1; c.wec = 1; c.hd = 1;
    access(1, 16'h010C, 2, 16'h0F0F, c);               // read->write same area
    c = '{default: 0};
    c.wcode = 14; c.gww = 0; c.bsl = 1;
    access(1, 16'h010E, 3, 16'hA5A5, c);               // write->write, zero gap
    c = '{default: 0};
    c.su = 7; c.hd = 7; c.crd = 7; c.rdc = 7; c.rdx = 1; c.wcode = 12;
    access(0, 16'h0110, 0, 0, c);                      // maximal read
    c = '{default: 0};
    c.grrs = 5; c.grrd = 2; c.wcode = 9;
    access(0, 16'h0112, 3, 0, c);                      // read->read other area
    c = '{default: 0};
    c.grws = 5; c.grwd = 4; c.su = 1; c.cwe = 7; c.wec = 7; c.hd = 2; c.wcode = 11;
    access(1, 16'h0114, 0, 16'h7E57, c);               // read->write other area
    c = '{default: 7};
    c.wcode = 15; c.rdx = 1; c.bsl = 1;
    cfg = c;                                           // R10 change after last accept
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(req_ready && bus_cs_n, "R2 idle after final access", int'({req_ready, bus_cs_n}), 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule